// File: doc/BRIEF.md
# Sync-Gated Serial Receive Bit Queue

This block sits behind a demodulator and clock-recovery stage that delivers one received bit per strobe on the core clock. While unlocked, it searches the incoming stream for a sync word whose value and length (1 to 16 bits) are set by configuration. The bit that completes a match sets a fill-enable latch. The sync bits themselves are never queued. From the next strobe on, every received bit is written into a 16-entry, one-bit-wide queue.

A level interrupt tells the host that enough bits are waiting. It is high whenever the stored bit count is at or above a programmable threshold of 1 to 16. The host drains the queue serially. It holds a select line high, samples the oldest bit on the data output, and gives a rising edge on its read clock to move on to the next bit. The read clock is asynchronous and must run below a quarter of the core clock, because it is synchronized internally. A synchronous clear drops the latch, empties the queue and clears the overflow flag, so the search starts again.

Top module: `syncRxFifo`

## Requirements
- R1: While `syncLocked` is low, no received bit is stored and `fifoLevel` stays 0.
- R2: On a strobe while unlocked, the block locks if the low `syncLen` bits of the last received bits (newest bit in bit 0) equal the low `syncLen` bits of `syncWord`, and at least `syncLen` bits have been received since reset or clear. Lock becomes visible one clock after the strobe.
- R3: The bit that completes the sync match is not stored, so `fifoLevel` is still 0 when `syncLocked` first reads high.
- R4: While locked and not full, each strobe stores `rxBit` and raises `fifoLevel` by one, one clock after the strobe.
- R5: `fifoIrq` is high exactly when `fifoLevel` >= `irqLevel`, where `irqLevel` ranges from 1 to 16. It updates in the same clock as the level.
- R6: While `hostSel` is high, `hostData` shows the oldest stored bit, or 0 when the queue is empty. While `hostSel` is low, `hostData` is 0.
- R7: A rising edge of `hostRdClk` while `hostSel` is high removes exactly one bit within four core clocks. Edges with `hostSel` low, or with an empty queue, change nothing.
- R8: A strobe that arrives while 16 bits are stored and no read is in progress drops its bit and sets `overflow`. `overflow` then stays high until clear.
- R9: One clock after `clearReq`, `syncLocked`, `fifoLevel` and `overflow` are all 0, and the sync search restarts with an empty history.
- R10: After reset, `syncLocked`, `fifoLevel`, `fifoIrq`, `overflow` and `hostData` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| clearReq | input | 1 | Synchronous clear: unlock, flush, clear overflow |
| rxBit | input | 1 | Received data bit |
| rxStrobe | input | 1 | One-cycle strobe qualifying `rxBit` |
| syncWord | input | 16 | Sync pattern, newest bit in bit 0 |
| syncLen | input | 5 | Sync pattern length, 1 to 16 |
| irqLevel | input | 5 | Interrupt threshold in bits, 1 to 16 |
| hostSel | input | 1 | Host queue select |
| hostRdClk | input | 1 | Host read clock (asynchronous, below clk/4) |
| hostData | output | 1 | Oldest stored bit while selected |
| fifoIrq | output | 1 | Level interrupt |
| fifoLevel | output | 5 | Number of stored bits |
| syncLocked | output | 1 | Fill-enable latch |
| overflow | output | 1 | Sticky drop flag |

## Verification
The assertions check four rules on every cycle: no storage while unlocked, interrupt agreement with the level, overflow stickiness, and the clear effect. They also check that the level never jumps by more than one and that an unselected output stays 0. Other behaviours can only be shown by the bench's scenarios. These are the exact bit on which a sync word of a given length locks, and the rule that the matching bit is not queued. They also include payload order on readout, dropped bits at full, and ignored read edges. The bench runs these against a bit-level model over noise, short and full-length patterns, and random configurations.

// File: rtl/syncRxPkg.sv
package syncRxPkg;
  // Strobes from control to datapath, valid for one core clock.
  typedef struct packed {
    logic push;   // store rxBit
    logic pop;    // host advanced read
    logic flush;  // empty storage, clear overflow
  } fifoCtl_t;
endpackage

// File: rtl/syncRxCtrl.sv
module syncRxCtrl
  import syncRxPkg::*;
#(
  parameter int PAT_W       = 16,
  parameter int SYNC_STAGES = 2,
  localparam int LEN_W      = $clog2(PAT_W + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clearReq,
  input  logic             rxBit,
  input  logic             rxStrobe,
  input  logic [PAT_W-1:0] syncWord,
  input  logic [LEN_W-1:0] syncLen,
  input  logic             hostSel,
  input  logic             hostRdClk,
  output fifoCtl_t         ctl,
  output logic             locked
);
  logic [PAT_W-1:0] shiftReg, shiftNext, lenMask;
  logic [LEN_W-1:0] seenCnt, seenNext;
  logic             patHit, enoughBits, hit;
  logic [SYNC_STAGES-1:0] rdSync;
  logic             rdPrev, rdRise;

  // Mask of the active pattern bits.
  always_comb begin
    for (int i = 0; i < PAT_W; i++) begin
      lenMask[i] = (LEN_W'(i) < syncLen);
    end
  end

  assign shiftNext  = {shiftReg[PAT_W-2:0], rxBit};
  assign seenNext   = (seenCnt == LEN_W'(PAT_W)) ? seenCnt : seenCnt + 1'b1;
  assign enoughBits = (seenNext >= syncLen);
  assign patHit     = (((shiftNext ^ syncWord) & lenMask) == '0);
  assign hit        = rxStrobe && !locked && patHit && enoughBits;

  always_ff @(posedge clk) begin
    if (!rstN || clearReq) begin
      shiftReg <= '0;
      seenCnt  <= '0;
      locked   <= 1'b0;
    end else if (rxStrobe && !locked) begin
      shiftReg <= shiftNext;
      seenCnt  <= seenNext;
      if (hit) locked <= 1'b1;
    end
  end

  // Read clock synchronizer and rising-edge detect.
  generate
    if (SYNC_STAGES == 1) begin : gSync1
      always_ff @(posedge clk) begin
        if (!rstN) rdSync <= '0;
        else       rdSync <= hostRdClk;
      end
    end else begin : gSyncN
      always_ff @(posedge clk) begin
        if (!rstN) rdSync <= '0;
        else       rdSync <= {rdSync[SYNC_STAGES-2:0], hostRdClk};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) rdPrev <= 1'b0;
    else       rdPrev <= rdSync[SYNC_STAGES-1];
  end

  assign rdRise = rdSync[SYNC_STAGES-1] && !rdPrev;

  always_comb begin
    ctl.flush = clearReq;
    ctl.push  = rxStrobe && locked && !clearReq;
    ctl.pop   = rdRise && hostSel && !clearReq;
  end
endmodule

// File: rtl/syncRxData.sv
module syncRxData
  import syncRxPkg::*;
#(
  parameter int DEPTH      = 16,
  localparam int CNT_W     = $clog2(DEPTH + 1),
  localparam int PTR_W     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  fifoCtl_t         ctl,
  input  logic             rxBit,
  input  logic             hostSel,
  input  logic [CNT_W-1:0] irqLevel,
  output logic             hostData,
  output logic [CNT_W-1:0] level,
  output logic             irq,
  output logic             overflow
);
  logic [DEPTH-1:0] bits;
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] levelNext;
  logic             full, empty, doPush, doPop, drop;

  assign full   = (level == CNT_W'(DEPTH));
  assign empty  = (level == '0);
  assign doPop  = ctl.pop && !empty;
  assign doPush = ctl.push && (!full || doPop);
  assign drop   = ctl.push && full && !doPop;

  always_comb begin
    levelNext = level;
    if (ctl.flush)             levelNext = '0;
    else if (doPush && !doPop) levelNext = level + 1'b1;
    else if (doPop && !doPush) levelNext = level - 1'b1;
  end

  function automatic logic [PTR_W-1:0] ptrInc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      level    <= '0;
      irq      <= 1'b0;
      overflow <= 1'b0;
    end else begin
      level <= levelNext;
      irq   <= (levelNext >= irqLevel);
      if (ctl.flush) begin
        wrPtr    <= '0;
        rdPtr    <= '0;
        overflow <= 1'b0;
      end else begin
        if (doPush) wrPtr <= ptrInc(wrPtr);
        if (doPop)  rdPtr <= ptrInc(rdPtr);
        if (drop)   overflow <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (doPush && !ctl.flush) bits[wrPtr] <= rxBit;
  end

  assign hostData = hostSel && !empty && bits[rdPtr];
endmodule

// File: rtl/syncRxFifo.sv
module syncRxFifo
  import syncRxPkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int PAT_W       = 16,
  parameter int SYNC_STAGES = 2,
  localparam int LEN_W      = $clog2(PAT_W + 1),
  localparam int CNT_W      = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clearReq,
  input  logic             rxBit,
  input  logic             rxStrobe,
  input  logic [PAT_W-1:0] syncWord,
  input  logic [LEN_W-1:0] syncLen,
  input  logic [CNT_W-1:0] irqLevel,
  input  logic             hostSel,
  input  logic             hostRdClk,
  output logic             hostData,
  output logic             fifoIrq,
  output logic [CNT_W-1:0] fifoLevel,
  output logic             syncLocked,
  output logic             overflow
);
  fifoCtl_t ctl;

  syncRxCtrl #(.PAT_W(PAT_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .clearReq(clearReq), .rxBit(rxBit),
    .rxStrobe(rxStrobe), .syncWord(syncWord), .syncLen(syncLen),
    .hostSel(hostSel), .hostRdClk(hostRdClk), .ctl(ctl), .locked(syncLocked)
  );

  syncRxData #(.DEPTH(DEPTH)) u_data (
    .clk(clk), .rstN(rstN), .ctl(ctl), .rxBit(rxBit), .hostSel(hostSel),
    .irqLevel(irqLevel), .hostData(hostData), .level(fifoLevel),
    .irq(fifoIrq), .overflow(overflow)
  );
endmodule

// File: rtl/syncRxChk.sv
module syncRxChk #(
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             clearReq,
  input logic             hostSel,
  input logic             hostData,
  input logic [CNT_W-1:0] irqLevel,
  input logic             fifoIrq,
  input logic [CNT_W-1:0] fifoLevel,
  input logic             syncLocked,
  input logic             overflow
);
  // R1
  no_store_unlocked_chk: assert property (@(posedge clk) disable iff (!rstN)
    !syncLocked |-> fifoLevel == '0);

  // R5
  irq_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoIrq == (fifoLevel >= $past(irqLevel)));

  // R8
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    overflow && !clearReq |=> overflow);

  // R8
  level_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoLevel <= CNT_W'(DEPTH));

  // R4
  level_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !clearReq |=> (fifoLevel == $past(fifoLevel) ||
                   fifoLevel == $past(fifoLevel) + 1'b1 ||
                   fifoLevel + 1'b1 == $past(fifoLevel)));

  // R9
  clear_effect_chk: assert property (@(posedge clk) disable iff (!rstN)
    clearReq |=> (fifoLevel == '0 && !syncLocked && !overflow));

  // R6
  idle_output_chk: assert property (@(posedge clk) disable iff (!rstN)
    !hostSel |-> !hostData);
endmodule

bind syncRxFifo syncRxChk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .clearReq(clearReq), .hostSel(hostSel),
  .hostData(hostData), .irqLevel(irqLevel), .fifoIrq(fifoIrq),
  .fifoLevel(fifoLevel), .syncLocked(syncLocked), .overflow(overflow)
);

// File: tb/tb_syncRxFifo.sv
module tb_syncRxFifo;
  logic        clk = 0, rstN = 0, clearReq = 0, rxBit = 0, rxStrobe = 0;
  logic [15:0] syncWord = 16'h2DD4;
  logic [4:0]  syncLen = 5'd16, irqLevel = 5'd8;
  logic        hostSel = 0, hostRdClk = 0;
  logic        hostData, fifoIrq, syncLocked, overflow;
  logic [4:0]  fifoLevel;

  int checks = 0, fails = 0;
  bit finished = 0;

  // Model state
  logic [15:0] mShift;
  int          mSeen;
  bit          mLocked, mOvf;
  bit          mQ[$];

  always #5 clk = ~clk;

  syncRxFifo dut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit modelHit(input logic [15:0] sh, input int seen);
    logic [15:0] mask;
    mask = (syncLen >= 16) ? 16'hFFFF : 16'((32'd1 << syncLen) - 1);
    return (seen >= int'(syncLen)) && (((sh ^ syncWord) & mask) == 16'h0);
  endfunction

  function automatic bit expIrq();
    return mQ.size() >= int'(irqLevel);
  endfunction

  task automatic modelReset();
    mShift = 0; mSeen = 0; mLocked = 0; mOvf = 0; mQ.delete();
  endtask

  task automatic checkState(input string req);
    check(fifoLevel == mQ.size(), {req, " level"}, fifoLevel, mQ.size());
    check(syncLocked == mLocked, {req, " locked"}, syncLocked, mLocked);
    check(fifoIrq == expIrq(), {req, " R5 irq"}, fifoIrq, expIrq());
    check(overflow == mOvf, {req, " overflow"}, overflow, mOvf);
  endtask

  task automatic sendBit(input bit b);
    bit wasLocked;
    wasLocked = mLocked;
    rxBit = b; rxStrobe = 1;
    @(negedge clk);
    rxStrobe = 0;
    if (!mLocked) begin
      mShift = {mShift[14:0], b};
      if (mSeen < 16) mSeen++;
      if (modelHit(mShift, mSeen)) mLocked = 1;
    end else if (mQ.size() < 16) mQ.push_back(b);
    else mOvf = 1;
    if (!mLocked) check(fifoLevel == 0, "R1 nothing stored", fifoLevel, 0);
    if (mLocked && !wasLocked) check(fifoLevel == 0, "R3 sync bit not stored", fifoLevel, 0);
    checkState(wasLocked ? "R4" : "R2");
  endtask

  task automatic sendPattern();
    for (int i = int'(syncLen) - 1; i >= 0; i--) sendBit(syncWord[i]);
  endtask

  task automatic readBit(input bit sel);
    bit expD;
    hostSel = sel;
    @(negedge clk);
    expD = (sel && mQ.size() > 0) ? mQ[0] : 1'b0;
    check(hostData == expD, "R6 data", hostData, expD);
    hostRdClk = 1;
    repeat (4) @(negedge clk);
    hostRdClk = 0;
    repeat (4) @(negedge clk);
    if (sel && mQ.size() > 0) void'(mQ.pop_front());
    hostSel = 0;
    checkState("R7");
  endtask

  task automatic doClear();
    clearReq = 1;
    @(negedge clk);
    clearReq = 0;
    modelReset();
    checkState("R9");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R10 reset state
    check(fifoLevel == 0 && !syncLocked && !fifoIrq && !overflow && !hostData,
          "R10 reset", fifoLevel, 0);

    // Noise, full-length pattern, payload, drain.
    for (int i = 0; i < 40; i++) sendBit(1'($urandom()));
    sendPattern();
    check(syncLocked, "R2 locked after pattern", syncLocked, 1);
    for (int i = 0; i < 12; i++) sendBit(1'($urandom()));
    readBit(0); // R7 edge ignored with select low
    while (mQ.size() > 0) readBit(1);
    readBit(1); // R7 empty read ignored, R6 shows 0

    // R2 directed: zero pattern of length 4 needs 4 received bits.
    doClear();
    syncWord = 16'h0000; syncLen = 5'd4; irqLevel = 5'd3;
    for (int i = 0; i < 3; i++) sendBit(0);
    check(!syncLocked, "R2 too few bits", syncLocked, 0);
    sendBit(0);
    check(syncLocked, "R2 lock on fourth bit", syncLocked, 1);
    for (int i = 0; i < 3; i++) sendBit(1);
    check(fifoIrq, "R5 irq at threshold", fifoIrq, 1);
    readBit(1);
    check(!fifoIrq, "R5 irq drops below threshold", fifoIrq, 0);

    // R8 overflow
    doClear();
    syncWord = 16'h00A5; syncLen = 5'd8; irqLevel = 5'd16;
    sendPattern();
    for (int i = 0; i < 20; i++) sendBit(1'($urandom()));
    check(overflow && fifoLevel == 16, "R8 full and flagged", fifoLevel, 16);
    readBit(1);
    check(overflow, "R8 flag sticky after read", overflow, 1);
    while (mQ.size() > 0) readBit(1);
    doClear();

    // Random configurations.
    for (int r = 0; r < 8; r++) begin
      int n;
      syncWord = 16'($urandom());
      syncLen  = 5'($urandom_range(16, 1));
      irqLevel = 5'($urandom_range(16, 1));
      for (int i = 0; i < 24; i++) sendBit(1'($urandom()));
      if (!mLocked) sendPattern();
      n = $urandom_range(20, 0);
      for (int i = 0; i < n; i++) sendBit(1'($urandom()));
      while (mQ.size() > 0) readBit(1);
      doClear();
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule